// File: doc/BRIEF.md
# Accelerator Control and Status Registers

This block is the software-facing control layer of a programmable accelerator core. It sits on a simple word-addressed register bus with address, write data, write enable, read enable and read data signals. On that bus it exposes a write-one launch command, a busy flag, an error record, an entry address, a permanent record of fatal causes, a saturating count of executed instructions, and a pending flag for the completion interrupt.

Toward the core it issues a one-cycle launch pulse and presents the entry address. From the core it receives:
- a busy level;
- a completion strobe;
- per-cause error strobes;
- an instruction-retired strobe with a fault qualifier;
- fatal cause strobes.

Toward the rest of the chip it drives the completion interrupt, a permanent fatal alert, a one-shot recoverable alert and an idle level.

A small run controller tracks each operation. It has four states:
- `ST_IDLE`: no operation is in progress.
- `ST_LAUNCH`: the one cycle in which the launch pulse is driven.
- `ST_RUN`: the core is executing.
- `ST_LOCK`: a fatal cause has been seen. This state is terminal until reset.

It has these transitions:
- `IDLE->LAUNCH`: an accepted launch write.
- `LAUNCH->RUN`: always taken after one cycle.
- `RUN->IDLE`: on the completion strobe.
- `any->LOCK`: on any fatal strobe, or while any fatal cause bit is set.

A launch write is accepted only when all of these hold:
- the controller is in `ST_IDLE`;
- the core is not busy;
- no fatal cause is recorded or arriving.

An accepted launch clears the error record and the instruction count.

Top module: `acc_ctrl_regs`

Register word offsets:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | launch command | write |
| 0x04 | status | read |
| 0x08 | error record | read |
| 0x0C | entry address | write |
| 0x10 | fatal cause | read |
| 0x14 | instruction count | read |
| 0x18 | interrupt pending | read, write-1-to-clear |

All register updates take effect on the clock edge that samples the bus write. Reads are combinational from the current register state.

## Requirements
- R1: Writing data with bit 0 set to offset 0x00, when the launch is accepted, makes `core_start` high for exactly the one cycle following the write edge. During that cycle `core_start_addr` equals the value last written to offset 0x0C. Offset 0x00 always reads as 0.
- R2: Bit 0 of offset 0x04 reads the current `core_busy`, and all other bits read 0. `idle` is high exactly when `core_busy` is low.
- R3: Offset 0x08 bits [7:0] hold the OR of all `core_err_strb` bits seen since the last accepted launch. Bit 0 is bad data address, bit 1 bad instruction address, bit 2 call stack fault, bit 3 illegal instruction, bit 4 loop fault, bit 5 fetch failure, bit 6 data read failure and bit 7 register read failure. An accepted launch clears the record to 0.
- R4: The entry address at offset 0x0C resets to 0 and is write-only, so reads of 0x0C return 0.
- R5: Offset 0x10 bits [3:0] record `fatal_strb` permanently until reset. Bit 0 is bus integrity, bit 1 instruction memory ECC, bit 2 data memory ECC and bit 3 register file ECC. Bits are recorded even while the core is idle, and launches never clear them.
- R6: `alert_fatal` rises in the cycle after the first fatal strobe and stays high until reset.
- R7: Offset 0x14 counts `core_retire` strobes that have `core_retire_fault` low. It holds at 2^CNT_W-1 instead of wrapping, and an accepted launch clears it to 0.
- R8: A launch write while `core_busy` is high, while an operation is in progress, or while any fatal cause is recorded produces no `core_start` pulse. Such a write also leaves the error record and the count unchanged.
- R9: A `core_done` strobe sets the interrupt pending bit, which is read at offset 0x18 bit 0 and drives `irq_done`. Writing data with bit 0 set to 0x18 clears the bit. If a done strobe and a clear write fall in the same cycle, the bit ends up set.
- R10: `alert_recov` is high for the one cycle after a `core_done` strobe if error record bits [4:0] are non-zero in that cycle, counting strobes of the same cycle. Otherwise `alert_recov` stays low.
- R11: Reads of unmapped offsets return 0, and `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, combinational |
| core_start | output | 1 | One-cycle launch pulse to the core |
| core_start_addr | output | 32 | Entry byte address for the core |
| core_busy | input | 1 | Core is running an operation |
| core_done | input | 1 | Core completed an operation |
| core_err_strb | input | 8 | Per-cause error strobes |
| core_retire | input | 1 | An instruction retired |
| core_retire_fault | input | 1 | The retiring instruction faulted |
| fatal_strb | input | 4 | Fatal cause strobes |
| irq_done | output | 1 | Completion interrupt, the pending bit |
| alert_fatal | output | 1 | Permanent fatal alert |
| alert_recov | output | 1 | One-shot recoverable alert |
| idle | output | 1 | Core is not busy |

## Verification
The interrupt pending bit can be set by the core's completion strobe and cleared by a software write to offset 0x18 in the same cycle. The bench provokes this by driving `core_done` in the very cycle that carries the clear write. It then expects the pending bit still set, reading 1 at 0x18 and seeing `irq_done` high, because a completion must never be lost. A later lone clear write must then bring the bit to 0, which shows that the clear path itself works.

// File: rtl/acc_ctrl_pkg.sv
package acc_ctrl_pkg;

    localparam int DATA_W  = 32;
    localparam int ERR_W   = 8;
    localparam int FATAL_W = 4;
    localparam int RECOV_W = 5;

    localparam logic [7:0] OFF_CMD    = 8'h00;
    localparam logic [7:0] OFF_STATUS = 8'h04;
    localparam logic [7:0] OFF_ERR    = 8'h08;
    localparam logic [7:0] OFF_ENTRY  = 8'h0C;
    localparam logic [7:0] OFF_FATAL  = 8'h10;
    localparam logic [7:0] OFF_COUNT  = 8'h14;
    localparam logic [7:0] OFF_IRQ    = 8'h18;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_LOCK   = 2'd3
    } run_state_e;

endpackage

// File: rtl/acc_run_fsm.sv
module acc_run_fsm
    import acc_ctrl_pkg::*;
#(
    parameter int FW = FATAL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          core_busy,
    input  logic          core_done,
    input  logic [FW-1:0] fatal_strb,
    input  logic          fatal_any,
    output logic          start_accept,
    output logic          core_start
);

    run_state_e state_q, state_d;
    logic       fatal_now;

    assign fatal_now = fatal_any || (fatal_strb != '0);

    always_comb begin
        start_accept = start_wr && (state_q == ST_IDLE) && !core_busy && !fatal_now;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_accept) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_RUN;
            ST_RUN:    if (core_done) state_d = ST_IDLE;
            ST_LOCK:   state_d = ST_LOCK;
            default:   state_d = ST_IDLE;
        endcase
        if (fatal_now) state_d = ST_LOCK;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        core_start = 1'b0;
        unique case (state_q)
            ST_LAUNCH: core_start = 1'b1;
            default:   core_start = 1'b0;
        endcase
    end

    // R1: the launch pulse lasts a single cycle
    a_r1_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R8: nothing launches while a fatal cause is recorded
    a_r8_no_launch_locked: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_any |=> !core_start);

endmodule

// File: rtl/acc_status_regs.sv
module acc_status_regs
    import acc_ctrl_pkg::*;
#(
    parameter int EW = ERR_W,
    parameter int FW = FATAL_W,
    parameter int RW = RECOV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_accept,
    input  logic [EW-1:0] err_strb,
    input  logic [FW-1:0] fatal_strb,
    input  logic          core_done,
    input  logic          irq_clr,
    output logic [EW-1:0] err_q,
    output logic [FW-1:0] fatal_q,
    output logic          fatal_any,
    output logic          irq_q,
    output logic          recov_q
);

    logic [EW-1:0] err_d;
    logic          recov_d;

    always_comb begin
        err_d   = (start_accept ? '0 : err_q) | err_strb;
        recov_d = core_done && ((err_q[RW-1:0] | err_strb[RW-1:0]) != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q   <= '0;
            irq_q   <= 1'b0;
            recov_q <= 1'b0;
        end else begin
            err_q   <= err_d;
            recov_q <= recov_d;
            if (core_done)    irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < FW; i++) begin : g_fatal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             fatal_q[i] <= 1'b0;
            else if (fatal_strb[i]) fatal_q[i] <= 1'b1;
        end
    end

    assign fatal_any = |fatal_q;

    // R5: recorded fatal causes never clear
    a_r5_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fatal_q & $past(fatal_q)) == $past(fatal_q)));

    // R9: a completion always leaves the interrupt pending
    a_r9_done_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> irq_q);

    // R10: the recoverable alert only follows a completion
    a_r10_recov_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        recov_q |-> $past(core_done));

    // R6: the fatal alert level never drops
    a_r6_fatal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_any |=> fatal_any);

endmodule

// File: rtl/acc_insn_counter.sv
module acc_insn_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             retire,
    input  logic             retire_fault,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic bump;

    assign bump = retire && !retire_fault && (count != CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (clr)  count <= '0;
        else if (bump) count <= count + 1'b1;
    end

    // R7: the count holds at its ceiling
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX));

    // R7: a faulting retire never advances the count
    a_r7_fault_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && retire_fault && !clr) |=> (count == $past(count)));

endmodule

// File: rtl/acc_ctrl_regs.sv
module acc_ctrl_regs
    import acc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    input  logic                bus_re,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                core_start,
    output logic [DATA_W-1:0]   core_start_addr,
    input  logic                core_busy,
    input  logic                core_done,
    input  logic [ERR_W-1:0]    core_err_strb,
    input  logic                core_retire,
    input  logic                core_retire_fault,
    input  logic [FATAL_W-1:0]  fatal_strb,
    output logic                irq_done,
    output logic                alert_fatal,
    output logic                alert_recov,
    output logic                idle
);

    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_ERR    = ADDR_W'(OFF_ERR);
    localparam logic [ADDR_W-1:0] A_ENTRY  = ADDR_W'(OFF_ENTRY);
    localparam logic [ADDR_W-1:0] A_FATAL  = ADDR_W'(OFF_FATAL);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_IRQ    = ADDR_W'(OFF_IRQ);

    logic                start_wr;
    logic                irq_clr;
    logic                start_accept;
    logic [DATA_W-1:0]   entry_q;
    logic [ERR_W-1:0]    err_q;
    logic [FATAL_W-1:0]  fatal_q;
    logic                fatal_any;
    logic                irq_q;
    logic                recov_q;
    logic [CNT_W-1:0]    count;

    assign start_wr = bus_we && (bus_addr == A_CMD) && bus_wdata[0];
    assign irq_clr  = bus_we && (bus_addr == A_IRQ) && bus_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                entry_q <= '0;
        else if (bus_we && (bus_addr == A_ENTRY))  entry_q <= bus_wdata;
    end

    acc_run_fsm #(.FW(FATAL_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_wr     (start_wr),
        .core_busy    (core_busy),
        .core_done    (core_done),
        .fatal_strb   (fatal_strb),
        .fatal_any    (fatal_any),
        .start_accept (start_accept),
        .core_start   (core_start)
    );

    acc_status_regs #(.EW(ERR_W), .FW(FATAL_W), .RW(RECOV_W)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_accept (start_accept),
        .err_strb     (core_err_strb),
        .fatal_strb   (fatal_strb),
        .core_done    (core_done),
        .irq_clr      (irq_clr),
        .err_q        (err_q),
        .fatal_q      (fatal_q),
        .fatal_any    (fatal_any),
        .irq_q        (irq_q),
        .recov_q      (recov_q)
    );

    acc_insn_counter #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (start_accept),
        .retire       (core_retire),
        .retire_fault (core_retire_fault),
        .count        (count)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (bus_addr == A_STATUS) bus_rdata[0]         = core_busy;
            if (bus_addr == A_ERR)    bus_rdata[ERR_W-1:0]   = err_q;
            if (bus_addr == A_FATAL)  bus_rdata[FATAL_W-1:0] = fatal_q;
            if (bus_addr == A_COUNT)  bus_rdata[CNT_W-1:0]   = count;
            if (bus_addr == A_IRQ)    bus_rdata[0]         = irq_q;
        end
    end

    assign core_start_addr = entry_q;
    assign irq_done        = irq_q;
    assign alert_fatal     = fatal_any;
    assign alert_recov     = recov_q;
    assign idle            = !core_busy;

    // R8: a launch write during a busy core never launches
    a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && core_busy) |=> !core_start);

    // R11: no read enable, no read data
    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |-> (bus_rdata == '0));

endmodule

// File: tb/tb_acc_ctrl_regs.sv
module tb_acc_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        core_start;
    logic [31:0] core_start_addr;
    logic        core_busy = 1'b0;
    logic        core_done = 1'b0;
    logic [7:0]  core_err_strb = '0;
    logic        core_retire = 1'b0;
    logic        core_retire_fault = 1'b0;
    logic [3:0]  fatal_strb = '0;
    logic        irq_done;
    logic        alert_fatal;
    logic        alert_recov;
    logic        idle;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #4 clk = ~clk;

    acc_ctrl_regs #(.ADDR_W(8), .CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .core_start(core_start), .core_start_addr(core_start_addr),
        .core_busy(core_busy), .core_done(core_done), .core_err_strb(core_err_strb),
        .core_retire(core_retire), .core_retire_fault(core_retire_fault),
        .fatal_strb(fatal_strb), .irq_done(irq_done), .alert_fatal(alert_fatal),
        .alert_recov(alert_recov), .idle(idle)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
    endtask

    // driver: pushes the expected read value, the monitor compares it
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_re = 1'b1;
        tick();
        bus_re = 1'b0;
    endtask

    // monitor: samples mid-cycle, away from the active edge
    always @(negedge clk) begin
        if (bus_re) begin
            if (sb_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard read with no expected item");
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic retire(input logic fault);
        core_retire = 1'b1; core_retire_fault = fault;
        tick();
        core_retire = 1'b0; core_retire_fault = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++; failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #3;
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // reset state
        check("R1 reset start", {31'b0, core_start}, 0);
        check("R6 reset fatal alert", {31'b0, alert_fatal}, 0);
        check("R9 reset irq", {31'b0, irq_done}, 0);
        check("R2 reset idle", {31'b0, idle}, 1);
        rd(8'h00, 0, "R1 cmd reads zero");
        rd(8'h04, 0, "R2 status idle");
        rd(8'h08, 0, "R3 err reset");
        rd(8'h0C, 0, "R4 entry reset");
        rd(8'h10, 0, "R5 fatal reset");
        rd(8'h14, 0, "R7 count reset");
        rd(8'h18, 0, "R9 irq reset");

        // launch
        wr(8'h0C, 32'h0000_0100);
        rd(8'h0C, 0, "R4 entry write-only");
        wr(8'h00, 32'h1);
        check("R1 start pulse", {31'b0, core_start}, 1);
        check("R1 start addr", core_start_addr, 32'h100);
        core_busy = 1'b1;
        tick();
        check("R1 pulse one cycle", {31'b0, core_start}, 0);
        check("R2 idle low when busy", {31'b0, idle}, 0);
        rd(8'h04, 1, "R2 status busy");

        // counting
        retire(1'b0); retire(1'b0); retire(1'b1); retire(1'b0);
        rd(8'h14, 3, "R7 count skips fault");

        // launch while busy is ignored
        wr(8'h00, 32'h1);
        check("R8 busy start ignored", {31'b0, core_start}, 0);
        rd(8'h14, 3, "R8 count kept");

        // errors
        core_err_strb = 8'h0A;
        tick();
        core_err_strb = 8'h00;
        rd(8'h08, 32'h0A, "R3 err sticky");
        core_err_strb = 8'h20;
        tick();
        core_err_strb = 8'h00;
        rd(8'h08, 32'h2A, "R3 err accumulates");

        // completion with recoverable error
        core_done = 1'b1; core_busy = 1'b0;
        tick();
        core_done = 1'b0;
        check("R10 recov pulse", {31'b0, alert_recov}, 1);
        check("R9 irq set", {31'b0, irq_done}, 1);
        tick();
        check("R10 recov one cycle", {31'b0, alert_recov}, 0);
        rd(8'h18, 1, "R9 irq pending read");
        wr(8'h18, 32'h1);
        check("R9 irq cleared", {31'b0, irq_done}, 0);

        // same cycle: done and clear, set wins
        core_done = 1'b1;
        wr(8'h18, 32'h1);
        core_done = 1'b0;
        check("R9 set wins over clear", {31'b0, irq_done}, 1);
        rd(8'h18, 1, "R9 pending after collision");
        wr(8'h18, 32'h1);
        check("R9 lone clear", {31'b0, irq_done}, 0);

        // second launch clears error record and count
        wr(8'h0C, 32'h0000_0200);
        wr(8'h00, 32'h1);
        check("R1 second pulse", {31'b0, core_start}, 1);
        check("R1 second addr", core_start_addr, 32'h200);
        core_busy = 1'b1;
        tick();
        rd(8'h08, 0, "R3 err cleared by launch");
        rd(8'h14, 0, "R7 count cleared by launch");
        for (int i = 0; i < 20; i++) retire(1'b0);
        rd(8'h14, 15, "R7 count saturates");

        // completion without error: no recoverable alert
        core_done = 1'b1; core_busy = 1'b0;
        tick();
        core_done = 1'b0;
        check("R10 no recov without error", {31'b0, alert_recov}, 0);
        wr(8'h18, 32'h1);

        // unmapped and quiet bus
        rd(8'h1C, 0, "R11 unmapped 1C");
        rd(8'h40, 0, "R11 unmapped 40");
        bus_addr = 8'h14;
        #1;
        check("R11 no read enable", bus_rdata, 0);

        // fatal while idle
        fatal_strb = 4'b0001;
        tick();
        fatal_strb = 4'b0000;
        check("R6 fatal alert raised", {31'b0, alert_fatal}, 1);
        rd(8'h10, 1, "R5 bus integrity while idle");
        wr(8'h00, 32'h1);
        check("R8 fatal start ignored", {31'b0, core_start}, 0);
        rd(8'h14, 15, "R8 count kept under fatal");
        fatal_strb = 4'b0100;
        tick();
        fatal_strb = 4'b0000;
        tick(); tick();
        rd(8'h10, 5, "R5 fatal accumulates");
        check("R6 fatal alert holds", {31'b0, alert_fatal}, 1);

        tick();
        finish_run();
    end

endmodule